// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block takes four asynchronous external interrupt request pins and turns them into clean requests for an interrupt controller. Each pin is first brought into the clock domain through a two-flop synchronizer. It is then interpreted under its own two-bit sense mode: active-high level, active-low level, rising edge or falling edge. Edge events are held in a per-pin latch until software acknowledges them. Level modes pass the synchronized pin straight through with no latching.

One 32-bit control register holds the whole configuration: the sense modes, per-pin enables, write-one-to-clear acknowledge bits, a master enable and a routing bit for pin 0. The host reaches it through a plain synchronous write strobe with data. The register value is always visible on the read bus. Pin 0 forms the critical-class request. Pins 1 to 3 drive main-class request lines 1 to 3.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control register reads 0 and every request output is 0.
- R2: The control register keeps only bits 23:16, 12, 11:8 and 0 of a write. All other bits, including the acknowledge bits 27:24, read back as 0.
- R3: With sense code 0 in bits (23-2n):(22-2n), pin n requests while its synchronized input is high.
- R4: With sense code 3, pin n requests while its synchronized input is low.
- R5: With sense code 1, a rising edge on pin n sets a request that stays asserted after the pin falls, until it is acknowledged.
- R6: With sense code 2, only a falling edge on pin n sets a held request. A rising edge does not set it.
- R7: Writing 1 to control bit (27-n) clears only the held request of pin n, in the write cycle itself. The held requests of the other pins are untouched.
- R8: In the level modes (codes 0 and 3), writing an acknowledge bit has no effect. The request keeps following the pin.
- R9: Control bit (11-n) enables pin n. While it is 0, pin n gives no request and records no edge, so enabling it later does not bring up a past edge.
- R10: While control bit 12 (master enable) is 0, no request output is asserted.
- R11: Pin 0's request appears on `crit_req` when control bit 0 is 1, and on `crit_alt_req` when it is 0. It never appears on both.
- R12: In a level mode a pin change reaches the output after two clock edges. In an edge mode the held request appears after three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Current control register value |
| irq_pin | input | 4 | Asynchronous external request pins |
| crit_req | output | 1 | Pin 0 request on the critical path |
| crit_alt_req | output | 1 | Pin 0 request on the alternate path |
| main_req | output | 3 | Main-class requests, index 1 to 3 from pins 1 to 3 |

## Verification
A wrong held-edge latch shows up at the ports on the very next clock. A request can stay high after an acknowledge, or after a change to a level mode. A latch that silently drops shows up as a request falling while the pin is quiet. Both are visible one edge after the cause. A wrong synchronizer depth or edge detector shows up as a request one cycle early or late, so the bench samples at exact edge counts after each pin change. A bad field decode shows up as the wrong pin responding, or as control bits that fail to read back.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int CTRL_W       = 32;
    localparam int MASTER_BIT   = 12;
    localparam int ROUTE_BIT    = 0;

    typedef enum logic [1:0] {
        SENSE_LVL_HIGH = 2'd0,
        SENSE_RISE     = 2'd1,
        SENSE_FALL     = 2'd2,
        SENSE_LVL_LOW  = 2'd3
    } sense_e;

    // bit positions depend on the pin index: mirrored layout
    function automatic int sense_lo_bit(input int n);
        return 22 - 2 * n;
    endfunction

    function automatic int enable_bit(input int n);
        return 11 - n;
    endfunction

    function automatic int ack_bit(input int n);
        return 27 - n;
    endfunction

    function automatic logic [CTRL_W-1:0] keep_mask(input int pins);
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int n = 0; n < pins; n++) begin
            m[sense_lo_bit(n)]     = 1'b1;
            m[sense_lo_bit(n) + 1] = 1'b1;
            m[enable_bit(n)]       = 1'b1;
        end
        m[MASTER_BIT] = 1'b1;
        m[ROUTE_BIT]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ext_irq_ctrl_reg.sv
module ext_irq_ctrl_reg
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [CTRL_W-1:0]        wdata,
    output logic [CTRL_W-1:0]        rdata,
    output logic [NUM_PINS-1:0][1:0] pin_mode,
    output logic [NUM_PINS-1:0]      pin_en,
    output logic [NUM_PINS-1:0]      pin_ack,
    output logic                     master_en,
    output logic                     crit_route
);
    localparam logic [CTRL_W-1:0] KEEP = keep_mask(NUM_PINS);

    logic [CTRL_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) ctrl_d = wdata & KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_fields
            assign pin_mode[g] = ctrl_q[sense_lo_bit(g) +: 2];
            assign pin_en[g]   = ctrl_q[enable_bit(g)];
            assign pin_ack[g]  = we & wdata[ack_bit(g)];
        end
    endgenerate

    assign master_en  = ctrl_q[MASTER_BIT];
    assign crit_route = ctrl_q[ROUTE_BIT];
    assign rdata      = ctrl_q;

    // R2: bits outside the kept fields never become visible
    p_unused_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~KEEP) == '0);

    // R1 / R2: a written value shows up masked on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata == ($past(wdata) & KEEP));

endmodule

// File: rtl/ext_irq_sense_cell.sv
module ext_irq_sense_cell
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic [1:0] mode,
    input  logic       gate,
    input  logic       ack,
    output logic       req
);
    typedef struct packed {
        logic prev;
        logic held;
    } cell_t;

    cell_t  st_d, st_q;
    sense_e mode_e;
    logic   edge_mode;
    logic   hit;
    logic   level_val;

    always_comb begin
        mode_e    = sense_e'(mode);
        edge_mode = (mode_e == SENSE_RISE) || (mode_e == SENSE_FALL);
        hit       = ((mode_e == SENSE_RISE) &&  pin_s && !st_q.prev) ||
                    ((mode_e == SENSE_FALL) && !pin_s &&  st_q.prev);
        level_val = (mode_e == SENSE_LVL_LOW) ? !pin_s : pin_s;

        st_d.prev = pin_s;
        if (!gate || !edge_mode) st_d.held = 1'b0;
        else if (hit)            st_d.held = 1'b1;
        else if (ack)            st_d.held = 1'b0;
        else                     st_d.held = st_q.held;

        req = gate && (edge_mode ? st_q.held : level_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_level_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> !st_q.held);

    p_disabled_no_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !st_q.held);

    p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !st_q.held);

    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && edge_mode && st_q.held && !ack && $stable(mode)) |=> st_q.held);

    p_prev_tracks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.prev == $past(pin_s));

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic [31:0]           ctrl_wdata,
    output logic [31:0]           ctrl_rdata,
    input  logic [NUM_PINS-1:0]   irq_pin,
    output logic                  crit_req,
    output logic                  crit_alt_req,
    output logic [NUM_PINS-1:1]   main_req
);
    logic [NUM_PINS-1:0][1:0] pin_mode;
    logic [NUM_PINS-1:0]      pin_en, pin_ack, pin_s, pin_req;
    logic                     master_en, crit_route;

    ext_irq_ctrl_reg #(.NUM_PINS(NUM_PINS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (ctrl_we),
        .wdata      (ctrl_wdata),
        .rdata      (ctrl_rdata),
        .pin_mode   (pin_mode),
        .pin_en     (pin_en),
        .pin_ack    (pin_ack),
        .master_en  (master_en),
        .crit_route (crit_route)
    );

    ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_pin),
        .sync_out (pin_s)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_cell
            ext_irq_sense_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .pin_s (pin_s[g]),
                .mode  (pin_mode[g]),
                .gate  (pin_en[g] & master_en),
                .ack   (pin_ack[g]),
                .req   (pin_req[g])
            );
        end
    endgenerate

    always_comb begin
        crit_req     = pin_req[0] &  crit_route;
        crit_alt_req = pin_req[0] & ~crit_route;
        main_req     = pin_req[NUM_PINS-1:1];
    end

    p_route_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(crit_req && crit_alt_req));

    p_master_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[MASTER_BIT] |-> (!crit_req && !crit_alt_req && main_req == '0));

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[enable_bit(1)] |-> !main_req[1]);

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ctrl_we = 0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [3:0]  irq_pin = '0;
    logic        crit_req, crit_alt_req;
    logic [3:1]  main_req;

    int total = 0;
    int bad = 0;

    ext_irq_sense dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .ctrl_rdata   (ctrl_rdata),
        .irq_pin      (irq_pin),
        .crit_req     (crit_req),
        .crit_alt_req (crit_alt_req),
        .main_req     (main_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk_ctrl(input logic [1:0] m0, input logic [1:0] m1,
                                            input logic [1:0] m2, input logic [1:0] m3,
                                            input logic [3:0] en, input logic master,
                                            input logic route);
        logic [31:0] v;
        v = '0;
        v[23:22] = m0; v[21:20] = m1; v[19:18] = m2; v[17:16] = m3;
        for (int n = 0; n < 4; n++) v[11-n] = en[n];
        v[12] = master;
        v[0]  = route;
        return v;
    endfunction

    function automatic logic [31:0] all_mode(input logic [1:0] m, input logic [3:0] en);
        return mk_ctrl(m, m, m, m, en, 1'b1, 1'b1);
    endfunction

    function automatic logic [3:0] reqs();
        return {main_req, crit_req | crit_alt_req};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_req(input string tag, input logic [3:0] exp);
        check(reqs() == exp, tag, {28'd0, reqs()}, {28'd0, exp});
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        ctrl_we = 1; ctrl_wdata = v;
        @(posedge clk);
        @(negedge clk);
        ctrl_we = 0; ctrl_wdata = '0;
    endtask

    task automatic pins(input logic [3:0] v);
        @(negedge clk);
        irq_pin = v;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(ctrl_rdata == 0, "R1 ctrl", ctrl_rdata, 0);
        check_req("R1 reqs", 4'b0000);
    endtask

    task automatic t_readback();
        wr(32'hFFFF_FFFF);
        check(ctrl_rdata == 32'h00FF_1F01, "R2 readback", ctrl_rdata, 32'h00FF_1F01);
        wr(32'h0);
    endtask

    task automatic t_level_high();
        wr(all_mode(2'd0, 4'hF));
        pins(4'b1010);
        check_req("R3 lvlhi a", 4'b1010);
        pins(4'b0101);
        check_req("R3 lvlhi b", 4'b0101);
    endtask

    task automatic t_level_low();
        wr(all_mode(2'd3, 4'hF));
        pins(4'b1010);
        check_req("R4 lvllo", 4'b0101);
        pins(4'b1111);
    endtask

    task automatic t_rising();
        pins(4'b0000);
        wr(all_mode(2'd1, 4'hF));
        pins(4'b1111);
        check_req("R5 rise set", 4'b1111);
        pins(4'b0000);
        check_req("R5 rise held", 4'b1111);
        wr(all_mode(2'd1, 4'hF) | 32'h0F00_0000);
        check_req("R7 ack all", 4'b0000);
    endtask

    task automatic t_falling();
        wr(all_mode(2'd2, 4'hF));
        pins(4'b1111);
        check_req("R6 rise ignored", 4'b0000);
        pins(4'b0000);
        check_req("R6 fall set", 4'b1111);
        pins(4'b1111);
        check_req("R6 fall held", 4'b1111);
    endtask

    task automatic t_ack_one();
        wr(all_mode(2'd2, 4'hF) | (32'h1 << 25));
        check_req("R7 ack pin2 only", 4'b1011);
        check(ctrl_rdata[27:24] == 0, "R2 ack reads 0", ctrl_rdata, 0);
    endtask

    task automatic t_ack_level();
        wr(all_mode(2'd0, 4'hF));
        pins(4'b1111);
        wr(all_mode(2'd0, 4'hF) | 32'h0F00_0000);
        check_req("R8 ack level", 4'b1111);
    endtask

    task automatic t_enable();
        pins(4'b0000);
        wr(all_mode(2'd0, 4'b0101));
        pins(4'b1111);
        check_req("R9 lvl en", 4'b0101);
        pins(4'b0000);
        wr(all_mode(2'd1, 4'b0101));
        pins(4'b1111);
        check_req("R9 edge en", 4'b0101);
        wr(all_mode(2'd1, 4'hF));
        check_req("R9 no stale edge", 4'b0101);
    endtask

    task automatic t_master();
        wr(mk_ctrl(0, 0, 0, 0, 4'hF, 1'b0, 1'b1));
        pins(4'b1111);
        check_req("R10 master off", 4'b0000);
        wr(mk_ctrl(0, 0, 0, 0, 4'hF, 1'b1, 1'b1));
        check_req("R10 master on", 4'b1111);
    endtask

    task automatic t_route();
        wr(mk_ctrl(0, 0, 0, 0, 4'hF, 1'b1, 1'b0));
        check(crit_alt_req && !crit_req, "R11 alt path",
              {30'd0, crit_req, crit_alt_req}, 32'd1);
        wr(mk_ctrl(0, 0, 0, 0, 4'hF, 1'b1, 1'b1));
        check(crit_req && !crit_alt_req, "R11 crit path",
              {30'd0, crit_req, crit_alt_req}, 32'd2);
    endtask

    task automatic t_latency();
        wr(mk_ctrl(0, 1, 0, 0, 4'hF, 1'b1, 1'b1));
        pins(4'b0000);
        irq_pin = 4'b0011;
        @(posedge clk); @(negedge clk);
        check(!crit_req, "R12 lvl 1 edge", {31'd0, crit_req}, 0);
        @(posedge clk); @(negedge clk);
        check(crit_req, "R12 lvl 2 edges", {31'd0, crit_req}, 1);
        check(!main_req[1], "R12 edge 2 edges", {31'd0, main_req[1]}, 0);
        @(posedge clk); @(negedge clk);
        check(main_req[1], "R12 edge 3 edges", {31'd0, main_req[1]}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_readback();
        t_level_high();
        t_level_low();
        t_rising();
        t_falling();
        t_ack_one();
        t_ack_level();
        t_enable();
        t_master();
        t_route();
        t_latency();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule